// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a block of words between a memory-mapped peripheral and main memory over one shared bus, with no processor work between setup and completion. Software writes four settings through a small register port: the transfer direction, the peripheral's bus address, the first memory word address and the number of words. It then sets the start bit. From that point the engine borrows the bus one word at a time. For each word it raises a request and waits for the grant. It then runs two bus cycles: a read from the source, which lands in an internal holding register, and a write of that word to the destination. After the write it lets go of the bus so the processor can continue. The processor stalls while the bus is borrowed, but it keeps its context.

After each word the memory pointer moves up by one word and the remaining count drops by one. When the count reaches zero the engine raises an interrupt. The interrupt stays asserted until software clears it. Every bus cycle may be stretched by the target, which holds the acknowledge low until it is ready.

Top module: `csdma_engine`

## Requirements
- R1: The register port has four word offsets, and read data is registered one clock after `cfg_addr`. Offset 0 is control: on write, bit 0 starts the transfer, bit 1 selects the direction (0 peripheral to memory, 1 memory to peripheral) and bit 2 clears the interrupt. On read, bit 0 shows busy, bit 1 the direction and bit 2 the interrupt. Offset 1 is the peripheral address, offset 2 the memory pointer and offset 3 the remaining count.
- R2: After synchronous reset, `bus_req`, `bus_valid`, `bus_we` and `irq` are low and every register reads as zero.
- R3: For each word the engine asserts `bus_req` and holds it until `bus_gnt` is high. No bus cycle starts without a grant.
- R4: Each word takes exactly two bus cycles. The first is a read of the source and the second is a write of that same word to the destination. With direction 0 the source is the peripheral address and the destination is the memory pointer; with direction 1 the two are swapped. The peripheral address stays fixed for the whole block.
- R5: After each word's write is acknowledged, the memory pointer rises by one and the count falls by one. A finished transfer reads back pointer = start + count and count = 0.
- R6: `bus_req` falls in the cycle after the write of a word is acknowledged, so the bus is requested anew for every word. An N-word block produces N separate request pulses.
- R7: `irq` rises when the last word has been written. It stays high until a control write with bit 2 set.
- R8: A start with a count of zero raises `irq` two clocks later with no bus request and no bus cycle.
- R9: While busy, every register write is ignored, including a second start.
- R10: A bus cycle holds `bus_valid`, `bus_addr` and `bus_we` steady until `bus_ack` is seen. Each cycle therefore lasts exactly one clock more than the target's wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word offset |
| cfg_wdata | input | max(AW,CW) | Register write data |
| cfg_rdata | output | max(AW,CW) | Registered read data for `cfg_addr` |
| irq | output | 1 | Completion interrupt, sticky |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | AW | Bus word address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, taken with `bus_ack` |
| bus_ack | input | 1 | Target acknowledge for the current bus cycle |

## Verification
A table of blocks is run in both directions. The rows mix grant delays of zero to five clocks, zero to three wait states per bus cycle, block lengths from one to eight words, and a memory start address that runs past the end of the modelled memory. Mixing the delays separates two things: a request that is dropped too early, which shows up as extra request pulses, and a bus cycle that does not wait for its acknowledge, which shows up as a wrong count of valid clocks. A transfer in the wrong direction, or with the wrong source and destination order, shows up as bad data at the peripheral log or in memory. Directed cases cover a zero-length start, writes and a second start arriving mid-transfer, and an interrupt that must survive idle cycles until it is cleared.

// File: rtl/csdma_pkg.sv
package csdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SRC,
    ST_DST,
    ST_REL,
    ST_DONE
  } st_e;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_DEV  = 2'd1;
  localparam logic [1:0] RA_MEM  = 2'd2;
  localparam logic [1:0] RA_CNT  = 2'd3;

  localparam int CB_START = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_CLR   = 2;

endpackage

// File: rtl/csdma_csr.sv
module csdma_csr
  import csdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = (AW > CW) ? AW : CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic          busy,
  input  logic          step,
  input  logic          done_pulse,
  output logic          start_go,
  output logic          dir,
  output logic [AW-1:0] dev_addr,
  output logic [AW-1:0] mem_addr,
  output logic [CW-1:0] count,
  output logic          cnt_zero,
  output logic          irq
);

  logic          wr_ok;
  logic          ctrl_wr;
  logic          clr_go;
  logic [RW-1:0] rd_nxt;

  // writes are only accepted while the engine is idle
  assign wr_ok    = cfg_wr && !busy;
  assign ctrl_wr  = wr_ok && (cfg_addr == RA_CTRL);
  assign start_go = ctrl_wr && cfg_wdata[CB_START];
  assign clr_go   = ctrl_wr && cfg_wdata[CB_CLR];
  assign cnt_zero = (count == '0);

  always_comb begin
    rd_nxt = '0;
    case (cfg_addr)
      RA_CTRL: begin
        rd_nxt[CB_START] = busy;
        rd_nxt[CB_DIR]   = dir;
        rd_nxt[CB_CLR]   = irq;
      end
      RA_DEV:  rd_nxt = RW'(dev_addr);
      RA_MEM:  rd_nxt = RW'(mem_addr);
      default: rd_nxt = RW'(count);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir       <= 1'b0;
      dev_addr  <= '0;
      mem_addr  <= '0;
      count     <= '0;
      irq       <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      if (ctrl_wr) dir <= cfg_wdata[CB_DIR];
      if (wr_ok && (cfg_addr == RA_DEV)) dev_addr <= cfg_wdata[AW-1:0];
      if (step) begin
        mem_addr <= mem_addr + AW'(1);
        count    <= count - CW'(1);
      end else begin
        if (wr_ok && (cfg_addr == RA_MEM)) mem_addr <= cfg_wdata[AW-1:0];
        if (wr_ok && (cfg_addr == RA_CNT)) count    <= cfg_wdata[CW-1:0];
      end
      if (done_pulse)  irq <= 1'b1;
      else if (clr_go) irq <= 1'b0;
      cfg_rdata <= rd_nxt;
    end
  end

  AST_DEV_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_wr && cfg_addr == RA_DEV) |=> $stable(dev_addr)); // R9
  AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_wr && cfg_addr == RA_CNT && !step) |=> $stable(count)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !(cfg_wr && cfg_addr == RA_CTRL && cfg_wdata[CB_CLR])) |=> irq); // R7

endmodule

// File: rtl/csdma_fsm.sv
module csdma_fsm
  import csdma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_go,
  input  logic cnt_zero,
  input  logic bus_gnt,
  input  logic bus_ack,
  output st_e  state,
  output logic busy,
  output logic step,
  output logic done_pulse,
  output logic hold_cap,
  output logic bus_req,
  output logic bus_valid,
  output logic bus_we
);

  st_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start_go) nxt = cnt_zero ? ST_DONE : ST_REQ;
      ST_REQ:  if (bus_gnt)  nxt = ST_SRC;
      ST_SRC:  if (bus_ack)  nxt = ST_DST;
      ST_DST:  if (bus_ack)  nxt = ST_REL;
      ST_REL:  nxt = cnt_zero ? ST_DONE : ST_REQ;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  // bus controls are flops loaded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_req   <= 1'b0;
      bus_valid <= 1'b0;
      bus_we    <= 1'b0;
    end else begin
      state     <= nxt;
      bus_req   <= (nxt == ST_REQ) || (nxt == ST_SRC) || (nxt == ST_DST);
      bus_valid <= (nxt == ST_SRC) || (nxt == ST_DST);
      bus_we    <= (nxt == ST_DST);
    end
  end

  assign busy       = (state != ST_IDLE);
  assign step       = (state == ST_DST) && bus_ack;
  assign hold_cap   = (state == ST_SRC) && bus_ack;
  assign done_pulse = (state == ST_DONE);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && !bus_valid) |=> bus_req); // R3
  AST_GNT_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) |-> $past(bus_gnt)); // R3
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we && bus_ack) |=> !bus_req); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_we))); // R10
  AST_ZERO_DONE: assert property (@(posedge clk) disable iff (rst)
    (start_go && cnt_zero) |=> (state == ST_DONE && !bus_req)); // R8

endmodule

// File: rtl/csdma_hold.sv
module csdma_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (cap) dout <= din;
  end

endmodule

// File: rtl/csdma_engine.sv
module csdma_engine
  import csdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_wr,
  input  logic [1:0]                   cfg_addr,
  input  logic [((AW>CW)?AW:CW)-1:0]   cfg_wdata,
  output logic [((AW>CW)?AW:CW)-1:0]   cfg_rdata,
  output logic                         irq,
  output logic                         bus_req,
  input  logic                         bus_gnt,
  output logic                         bus_valid,
  output logic                         bus_we,
  output logic [AW-1:0]                bus_addr,
  output logic [DW-1:0]                bus_wdata,
  input  logic [DW-1:0]                bus_rdata,
  input  logic                         bus_ack
);

  localparam int RW = (AW > CW) ? AW : CW;

  st_e           state;
  logic          busy, step, done_pulse, hold_cap;
  logic          start_go, dir, cnt_zero;
  logic [AW-1:0] dev_addr, mem_addr;
  logic [CW-1:0] count;

  csdma_csr #(.AW(AW), .CW(CW), .RW(RW)) u_csr (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .busy       (busy),
    .step       (step),
    .done_pulse (done_pulse),
    .start_go   (start_go),
    .dir        (dir),
    .dev_addr   (dev_addr),
    .mem_addr   (mem_addr),
    .count      (count),
    .cnt_zero   (cnt_zero),
    .irq        (irq)
  );

  csdma_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_go   (start_go),
    .cnt_zero   (cnt_zero),
    .bus_gnt    (bus_gnt),
    .bus_ack    (bus_ack),
    .state      (state),
    .busy       (busy),
    .step       (step),
    .done_pulse (done_pulse),
    .hold_cap   (hold_cap),
    .bus_req    (bus_req),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we)
  );

  csdma_hold #(.DW(DW)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .cap  (hold_cap),
    .din  (bus_rdata),
    .dout (bus_wdata)
  );

  // source first, destination second; direction swaps the two
  always_comb begin
    case (state)
      ST_SRC:  bus_addr = dir ? mem_addr : dev_addr;
      ST_DST:  bus_addr = dir ? dev_addr : mem_addr;
      default: bus_addr = '0;
    endcase
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we && bus_ack) |=> (mem_addr == $past(mem_addr) + AW'(1))); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ack) |=> $stable(bus_addr)); // R10
  AST_DEV_SIDE: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && (bus_we == dir)) |-> (bus_addr == dev_addr)); // R4

endmodule

// File: tb/csdma_engine_tb.sv
`timescale 1ns/1ps
module csdma_engine_tb;
  import csdma_pkg::*;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int RW = 16;
  localparam int NV = 6;
  localparam logic [31:0] DEV_BASE = 32'hD000_0000;

  // dir | grant delay | wait states | count | peripheral addr | memory addr | pad
  localparam logic [63:0] VECS [NV] = '{
    64'h00004F0010010000,
    64'h10005F0020020000,
    64'h03203F01000FE000,
    64'h12306F0AA0040000,
    64'h01101FFFF0080000,
    64'h15008F1230090000
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [RW-1:0] cfg_wdata = '0;
  logic [RW-1:0] cfg_rdata;
  logic          irq, bus_req, bus_valid, bus_we;
  logic          bus_gnt = 1'b0;
  logic          bus_ack = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  csdma_engine #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  int checks = 0;
  int fails = 0;
  logic done_flag = 1'b0;

  // bus model: arbiter, memory, and a peripheral in the top 4K of the map
  logic [31:0] mem [256];
  logic [31:0] dev_log [256];
  int dev_rd = 0, dev_wr = 0, req_rises = 0, xfers = 0, valid_cyc = 0;
  int gcnt = 0, wcnt = 0, gdly = 0, adly = 0;
  logic req_prev = 1'b0;
  logic bad_dev = 1'b0;
  logic [15:0] exp_dev = '0;

  always @(negedge clk) begin
    if (rst) begin
      bus_gnt = 1'b0; bus_ack = 1'b0; gcnt = 0; wcnt = 0; req_prev = 1'b0;
    end else begin
      if (bus_req && !req_prev) req_rises++;
      req_prev = bus_req;
      if (bus_req) begin
        if (gcnt >= gdly) bus_gnt = 1'b1;
        else begin bus_gnt = 1'b0; gcnt++; end
      end else begin
        bus_gnt = 1'b0; gcnt = 0;
      end
      if (bus_valid) begin
        valid_cyc++;
        if (wcnt >= adly) begin
          bus_ack = 1'b1; wcnt = 0; xfers++;
          if (bus_addr[15:12] == 4'hF) begin
            if (bus_addr != exp_dev) bad_dev = 1'b1;
            if (bus_we) begin dev_log[dev_wr[7:0]] = bus_wdata; dev_wr++; end
            else begin bus_rdata = DEV_BASE + 32'(dev_rd); dev_rd++; end
          end else begin
            if (bus_we) mem[bus_addr[7:0]] = bus_wdata;
            else bus_rdata = mem[bus_addr[7:0]];
          end
        end else begin
          bus_ack = 1'b0; wcnt++;
        end
      end else begin
        bus_ack = 1'b0; wcnt = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [RW-1:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    chk(req, 32'(irq), 32'd1);
  endtask

  function automatic logic [31:0] pat(input logic [15:0] m, input int i);
    return 32'h5A00_0000 + 32'(m) * 32'h100 + 32'(i);
  endfunction

  logic [RW-1:0] rd;
  int rd0, wr0, rr0, xf0, vc0, bad;

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; dev_log[i] = '0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R2 bus_req", 32'(bus_req), 0);
    chk("R2 bus_valid", 32'(bus_valid), 0);
    chk("R2 irq", 32'(irq), 0);
    cfg_read(RA_CTRL, rd); chk("R2 ctrl", 32'(rd), 0);
    cfg_read(RA_MEM, rd);  chk("R2 mem ptr", 32'(rd), 0);

    // table of blocks
    for (int v = 0; v < NV; v++) begin
      logic        vdir;
      int          vcnt, vad;
      logic [15:0] vdev, vmem;
      vdir = VECS[v][60];
      gdly = int'(VECS[v][59:56]);
      vad  = int'(VECS[v][55:52]);
      adly = vad;
      vcnt = int'(VECS[v][51:44]);
      vdev = VECS[v][43:28];
      vmem = VECS[v][27:12];
      exp_dev = vdev;
      if (vdir) for (int i = 0; i < vcnt; i++) mem[(32'(vmem) + 32'(i)) & 255] = pat(vmem, i);
      rd0 = dev_rd; wr0 = dev_wr; rr0 = req_rises; xf0 = xfers; vc0 = valid_cyc;
      cfg_write(RA_DEV, vdev);
      cfg_write(RA_MEM, vmem);
      cfg_write(RA_CNT, RW'(vcnt));
      cfg_write(RA_CTRL, {14'd0, vdir, 1'b1});
      wait_irq("R7 irq at end");
      bad = 0;
      for (int i = 0; i < vcnt; i++) begin
        if (vdir) begin
          if (dev_log[(wr0 + i) & 255] !== pat(vmem, i)) bad++;
        end else begin
          if (mem[(32'(vmem) + 32'(i)) & 255] !== DEV_BASE + 32'(rd0 + i)) bad++;
        end
      end
      chk("R4 data moved", 32'(bad), 0);
      chk("R4 peripheral addr", 32'(bad_dev), 0);
      chk("R4 two cycles per word", 32'(xfers - xf0), 32'(2 * vcnt));
      chk("R6 one request per word", 32'(req_rises - rr0), 32'(vcnt));
      chk("R10 valid clocks", 32'(valid_cyc - vc0), 32'(2 * vcnt * (vad + 1)));
      cfg_read(RA_MEM, rd); chk("R5 final ptr", 32'(rd), 32'(vmem + 16'(vcnt)));
      cfg_read(RA_CNT, rd); chk("R5 final count", 32'(rd), 0);
      cfg_read(RA_CTRL, rd); chk("R1 ctrl status", 32'(rd), {29'd0, 1'b1, vdir, 1'b0});
      repeat (5) @(negedge clk);
      chk("R7 irq held", 32'(irq), 1);
      cfg_write(RA_CTRL, 16'h0004);
      chk("R7 irq cleared", 32'(irq), 0);
    end

    // zero-length start
    gdly = 0; adly = 0;
    rr0 = req_rises; xf0 = xfers;
    cfg_write(RA_CNT, 16'd0);
    cfg_write(RA_CTRL, 16'h0001);
    @(negedge clk);
    chk("R8 irq on zero count", 32'(irq), 1);
    chk("R8 no bus cycles", 32'(xfers - xf0), 0);
    chk("R8 no request", 32'(req_rises - rr0), 0);
    cfg_write(RA_CTRL, 16'h0004);

    // writes while busy are dropped
    gdly = 6; adly = 1; exp_dev = 16'hF055;
    rd0 = dev_rd; xf0 = xfers;
    cfg_write(RA_DEV, 16'hF055);
    cfg_write(RA_MEM, 16'h0060);
    cfg_write(RA_CNT, 16'd4);
    cfg_write(RA_CTRL, 16'h0001);
    cfg_write(RA_DEV, 16'hF777);
    cfg_write(RA_CNT, 16'd50);
    cfg_write(RA_MEM, 16'h0099);
    cfg_write(RA_CTRL, 16'h0003);
    cfg_read(RA_CTRL, rd); chk("R9 busy shown", 32'(rd[0]), 1);
    wait_irq("R9 completes");
    cfg_read(RA_DEV, rd); chk("R9 dev kept", 32'(rd), 32'h0000_F055);
    cfg_read(RA_MEM, rd); chk("R9 ptr kept", 32'(rd), 32'h0000_0064);
    cfg_read(RA_CNT, rd); chk("R9 count kept", 32'(rd), 0);
    cfg_read(RA_CTRL, rd); chk("R9 dir kept", 32'(rd[1]), 0);
    chk("R9 second start ignored", 32'(xfers - xf0), 8);
    chk("R9 data", mem[8'h63], DEV_BASE + 32'(rd0 + 3));

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #750000;
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule